// File: doc/BRIEF.md
# Debug Register Target with Four-Phase Handshake

This block sits on the system-clock side of a small debug bus and serves a bank of 64-bit debug registers to a bus master, which is normally a bridge from a JTAG port. The master raises a request together with an 8-bit address, a write/read select and 64-bit write data. The target takes all of these on the first clock edge where it sees the request high. It performs the access exactly once and then raises an acknowledge. The acknowledge and any read data stay steady until the master drops the request.

The master may leave the request high for an unbounded time, for example when its own clock stops. The target then holds its response and does not repeat the access. When the request falls, the acknowledge drops one clock later. A new request is taken on the first clock it is seen high after that.

Top module: `dbg_reg_target`

## Requirements
- R1: After synchronous reset, ack is 0, the read data output is 0 and every implemented register reads back as 0.
- R2: When req is sampled high while ack is low, ack is high from the next clock on; a write (wr=1) is committed to the register bank on that same sampling edge.
- R3: While req stays high, ack stays high and the read data output stays unchanged, for any number of cycles.
- R4: Once req is sampled low while ack is high, ack is low from the next clock on.
- R5: A read (wr=0) of address 0 to 7 returns the value most recently written to that address.
- R6: A read of address 8 to 255 returns 0; a write to such an address is acknowledged and changes no implemented register.
- R7: Each request executes once. Changes to addr, wr or write data while ack is held have no effect on the bank or on the returned data.
- R8: A request raised on the first clock after ack has fallen is accepted with the same one-clock latency as R2.
- R9: A reset applied after registers were written clears all of them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request from the bus master |
| wr | input | 1 | 1 = write, 0 = read, valid with req |
| addr | input | 8 | Register address, valid with req |
| wdata | input | 64 | Write data, valid with req |
| ack | output | 1 | Acknowledge, held while req is high |
| rdata | output | 64 | Read data, held from ack rising until req falls |

## Verification
The bench builds the block with its default 8-bit address, 64-bit data and eight registers. With these values every one of the 256 addresses can be written and read back in one sweep. That sweep shows that out-of-range writes never alias into the eight implemented registers. Hold lengths from one cycle up to a long stuck request are covered, and addr, wr and data are scrambled during the hold. Back-to-back requests run at the minimum spacing.

// File: rtl/dbgt_pkg.sv
package dbgt_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } hsState_e;

  typedef struct packed {
    logic capture;
    logic commitWr;
    logic loadRd;
  } ctrlStrb_t;
endpackage

// File: rtl/dbgt_ctrl.sv
module dbgt_ctrl
  import dbgt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req,
  input  logic      wr,
  output logic      ackOut,
  output ctrlStrb_t strb
);
  hsState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strb = '0;
    case (state)
      ST_IDLE: if (req) begin
        stateNext = ST_HOLD;
        strb.capture = 1'b1;
        strb.commitWr = wr;
        strb.loadRd = !wr;
      end
      ST_HOLD: if (!req) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else state <= stateNext;
  end

  assign ackOut = (state == ST_HOLD);

  // R2: a request seen while ack is low yields ack on the next clock
  assert_ack_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (!ackOut && req) |=> ackOut);
  // R3: ack holds while req stays high
  assert_ack_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (ackOut && req) |=> ackOut);
  // R4: ack drops one clock after req is seen low
  assert_ack_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (ackOut && !req) |=> !ackOut);
  // R7: no capture strobe while the response is held
  assert_single_exec_R7: assert property (@(posedge clk) disable iff (rst)
    ackOut |-> !strb.capture);
endmodule

// File: rtl/dbgt_datapath.sv
module dbgt_datapath
  import dbgt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrb_t         strb,
  input  logic              ackIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DATA_W-1:0] bank [NUM_REGS];
  logic [IDX_W-1:0]  regIdx;
  logic              addrHit;
  logic [DATA_W-1:0] selData;
  logic [DATA_W-1:0] rdHold;

  assign addrHit = ({{(32-ADDR_W){1'b0}}, addr} < 32'(NUM_REGS));
  assign regIdx  = addr[IDX_W-1:0];

  always_comb begin
    selData = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (addrHit && (32'(regIdx) == 32'(k))) selData = bank[k];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gRegs
    logic wrHere;
    assign wrHere = strb.commitWr && addrHit && (32'(regIdx) == 32'(g));
    always_ff @(posedge clk) begin
      if (rst) bank[g] <= '0;
      else if (wrHere) bank[g] <= wdata;
    end
    // R7: a register changes only on a capture edge of a write
    assert_reg_quiet_R7: assert property (@(posedge clk) disable iff (rst)
      !strb.commitWr |=> $stable(bank[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) rdHold <= '0;
    else if (strb.loadRd) rdHold <= selData;
  end

  assign rdata = rdHold;

  // R3: returned data is steady while ack is held
  assert_rdata_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (ackIn && !strb.capture) |=> $stable(rdata));
  // R6: out-of-range reads return zero
  assert_oob_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (strb.loadRd && !addrHit) |=> (rdata == '0));
endmodule

// File: rtl/dbg_reg_target.sv
module dbg_reg_target
  import dbgt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata
);
  ctrlStrb_t strb;
  logic      ackInt;

  dbgt_ctrl uCtrl (
    .clk(clk), .rst(rst), .req(req), .wr(wr),
    .ackOut(ackInt), .strb(strb)
  );

  dbgt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .ackIn(ackInt),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  assign ack = ackInt;
endmodule

// File: tb/sim_dbg_reg_target.sv
module sim_dbg_reg_target;
  logic clk = 1'b0;
  logic rst, req, wr, ack;
  logic [7:0]  addr;
  logic [63:0] wdata, rdata;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dbg_reg_target u0 (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr),
    .wdata(wdata), .ack(ack), .rdata(rdata)
  );

  function automatic logic [63:0] pat(input int a, input int salt);
    return {a[7:0], 8'(salt), 48'h5A3C_9E17_0000} ^ (64'(a) * 64'h0001_0003_0007_000B);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Performs one access starting at a negedge; ends at a negedge with ack low.
  task automatic access(input logic w, input int a, input logic [63:0] d,
                        input int hold, input bit scramble, output logic [63:0] got);
    logic [63:0] first;
    chk("R8 ack low before request", 64'(ack), 64'd0);
    req = 1; wr = w; addr = 8'(a); wdata = d;
    @(negedge clk);
    chk("R2 ack one clock after request", 64'(ack), 64'd1);
    first = rdata;
    got = rdata;
    for (int i = 0; i < hold; i++) begin
      if (scramble) begin
        wr = ~wr; addr = addr ^ 8'h05; wdata = ~wdata;
      end
      @(negedge clk);
      chk("R3 ack held", 64'(ack), 64'd1);
      chk("R3 rdata stable", rdata, first);
    end
    req = 0;
    @(negedge clk);
    chk("R4 ack drops after req low", 64'(ack), 64'd0);
  endtask

  initial begin
    logic [63:0] got;
    rst = 1; req = 0; wr = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 ack after reset", 64'(ack), 64'd0);
    chk("R1 rdata after reset", rdata, 64'd0);
    for (int a = 0; a < 8; a++) begin
      access(0, a, 64'd0, 0, 0, got);
      chk("R1 reg zero after reset", got, 64'd0);
    end
    // full write sweep then read sweep
    for (int a = 0; a < 256; a++) access(1, a, pat(a, 1), a % 3, 0, got);
    for (int a = 0; a < 256; a++) begin
      access(0, a, 64'd0, a % 2, 0, got);
      if (a < 8) chk("R5 readback", got, pat(a, 1));
      else chk("R6 out-of-range read zero", got, 64'd0);
    end
    // R6: out-of-range writes did not alias (re-read after extra writes)
    for (int a = 8; a < 40; a++) access(1, a, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, got);
    for (int a = 0; a < 8; a++) begin
      access(0, a, 64'd0, 0, 0, got);
      chk("R6 no alias of ignored writes", got, pat(a, 1));
    end
    // R7: scramble during hold on writes and reads
    access(1, 2, pat(2, 7), 6, 1, got);
    access(0, 7, 64'd0, 0, 0, got);
    chk("R7 neighbour untouched", got, pat(7, 1));
    access(0, 2, 64'd0, 5, 1, got);
    chk("R7 write executed once", got, pat(2, 7));
    // stuck request
    access(0, 3, 64'd0, 60, 0, got);
    chk("R3 long hold data", got, pat(3, 1));
    // R9: reset clears written registers
    rst = 1;
    @(negedge clk);
    rst = 0;
    for (int a = 0; a < 8; a++) begin
      access(0, a, 64'd0, 0, 0, got);
      chk("R9 reg zero after second reset", got, 64'd0);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule